// File: doc/BRIEF.md
# Filtered pin edge interrupt detector

This block watches a bank of asynchronous input pins and turns selected transitions on them into per-pin interrupt flags. Every pin first crosses into the clock domain through a two-flop synchronizer. It then goes through an optional glitch filter. After that comes an edge detector, which can fire on any change, on rising edges only or on falling edges only. A detected event sets a sticky flag. The flag stays set until software clears it for that pin.

Software uses a simple write port to set a pin's filter enable, interrupt enable and trigger mode. The same port rejects a mode code that does not exist and reports the rejection. A second port clears one pin's flag at a time. The flags and the conditioned pin levels are exposed as vectors. A single request line is the OR of every flag whose pin interrupt is enabled.

Top module: `pin_event_irq`

## Requirements
- R1: Trigger mode codes are 0 = any change, 1 = rising only, 2 = falling only. A pin's flag sets only on a transition of its conditioned level that matches its mode.
- R2: A configuration write with mode code 3, or with a pin index beyond the bank, is rejected. `cfg_err_o` reads 1 in the cycle after the write, and the pin keeps its previous filter enable, interrupt enable and mode. `cfg_err_o` reads 0 after a valid write.
- R3: With the filter off, a pin change applied before clock edge k shows on `level_o` after edge k+1, and the matching flag shows after edge k+2.
- R4: With the filter on, a low or high excursion that is sampled for only one clock, or that falls entirely between two clock edges, never changes `level_o` and sets no flag.
- R5: With the filter on, a level held for two clocks or more always reaches `level_o`, exactly two clocks later than with the filter off (after edge k+3), and the flag follows one clock later.
- R6: An excursion lasting between one and two clocks may or may not pass the filter. In either case the filtered level settles back to the resting input.
- R7: Each pin has its own filter enable, interrupt enable, mode and flag. Activity on one pin never changes another pin's flag.
- R8: While a pin's interrupt is disabled, its flag does not set. A flag that is already set stays set.
- R9: A flag stays set until a clear names its pin. A clear affects only that pin.
- R10: When a flag's set event and its clear request fall in the same cycle, the flag ends up set.
- R11: `irq_o` is 1 exactly when some pin has both its flag and its interrupt enable set. Disabling the interrupt of a flagged pin drops `irq_o` but keeps the flag.
- R12: After reset all flags, levels, `irq_o` and `cfg_err_o` read 0. Every pin starts with its filter and interrupt disabled and its mode set to any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw asynchronous pin inputs |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_pin_i | input | IDX_W | Pin index of the configuration write |
| cfg_filt_i | input | 1 | Glitch filter enable to write |
| cfg_irq_i | input | 1 | Interrupt enable to write |
| cfg_mode_i | input | 2 | Trigger mode code to write |
| cfg_err_o | output | 1 | Previous configuration write was rejected |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_pin_i | input | IDX_W | Pin index whose flag is cleared |
| flags_o | output | NPINS | Sticky interrupt flags |
| level_o | output | NPINS | Conditioned pin levels |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The two functions that can land in the same cycle are a flag's set event and a software clear of that flag. The bench changes a pin and uses the fixed path latency to place the clear strobe on exactly the clock edge where the flag sets. It then expects the flag to read 1 afterwards. A later clear with no event pending must return the flag to 0.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  typedef enum logic [1:0] {
    TRIG_ANY  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2
  } trig_mode_e;

  function automatic logic trig_code_ok(input logic [1:0] code);
    return (code == 2'd0) || (code == 2'd1) || (code == 2'd2);
  endfunction

endpackage

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank
  import pin_evt_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       pin_i,
  input  logic                   filt_i,
  input  logic                   irq_i,
  input  logic [1:0]             mode_i,
  output logic [NPINS-1:0]       filt_en_o,
  output logic [NPINS-1:0]       irq_en_o,
  output trig_mode_e [NPINS-1:0] mode_o,
  output logic                   err_o
);

  logic                   accept;
  logic                   err_d;
  logic [NPINS-1:0]       sel;
  logic [NPINS-1:0]       filt_en_q;
  logic [NPINS-1:0]       irq_en_q;
  trig_mode_e [NPINS-1:0] mode_q;
  logic                   err_q;

  always_comb begin
    accept = we_i && trig_code_ok(mode_i) && (int'(pin_i) < NPINS);
    err_d  = we_i && !accept;
  end

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_slot
      assign sel[g] = accept && (int'(pin_i) == g);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          filt_en_q[g] <= 1'b0;
          irq_en_q[g]  <= 1'b0;
          mode_q[g]    <= TRIG_ANY;
        end else if (sel[g]) begin
          filt_en_q[g] <= filt_i;
          irq_en_q[g]  <= irq_i;
          mode_q[g]    <= trig_mode_e'(mode_i);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign filt_en_o = filt_en_q;
  assign irq_en_o  = irq_en_q;
  assign mode_o    = mode_q;
  assign err_o     = err_q;

  // R2
  bad_mode_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (mode_i == 2'd3)) |=> ($stable(filt_en_q) && $stable(irq_en_q) && $stable(mode_q)));

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic filt_en_i,
  output logic level_o
);

  logic s1_q, s2_q, prev_q, filt_q;
  logic filt_d;

  always_comb begin
    filt_d = (s2_q == prev_q) ? s2_q : filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      filt_q <= filt_d;
    end
  end

  assign level_o = filt_en_i ? filt_q : s2_q;

  // R4
  filt_needs_two_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (($past(s2_q, 1) == $past(s2_q, 2)) && (filt_q == $past(s2_q))));

endmodule

// File: rtl/pin_edge_flag.sv
module pin_edge_flag
  import pin_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic       irq_en_i,
  input  trig_mode_e mode_i,
  input  logic       clr_i,
  output logic       flag_o
);

  logic lvl_q, flag_q;
  logic evt, set, flag_en, flag_d;

  always_comb begin
    unique case (mode_i)
      TRIG_ANY:  evt = level_i ^ lvl_q;
      TRIG_RISE: evt = level_i & ~lvl_q;
      TRIG_FALL: evt = ~level_i & lvl_q;
      default:   evt = 1'b0;
    endcase
    set     = irq_en_i & evt;
    flag_en = set | clr_i;
    flag_d  = set | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lvl_q <= level_i;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R8
  flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(irq_en_i));

  // R9
  flag_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_i));

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_evt_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_pin_i,
  input  logic             cfg_filt_i,
  input  logic             cfg_irq_i,
  input  logic [1:0]       cfg_mode_i,
  output logic             cfg_err_o,
  input  logic             clr_we_i,
  input  logic [IDX_W-1:0] clr_pin_i,
  output logic [NPINS-1:0] flags_o,
  output logic [NPINS-1:0] level_o,
  output logic             irq_o
);

  logic                   rst_meta_q, rst_sync_q;
  logic [NPINS-1:0]       filt_en, irq_en, clr_vec, lvl, flags;
  trig_mode_e [NPINS-1:0] mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pin_cfg_bank #(.NPINS(NPINS), .IDX_W(IDX_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .we_i     (cfg_we_i),
    .pin_i    (cfg_pin_i),
    .filt_i   (cfg_filt_i),
    .irq_i    (cfg_irq_i),
    .mode_i   (cfg_mode_i),
    .filt_en_o(filt_en),
    .irq_en_o (irq_en),
    .mode_o   (mode),
    .err_o    (cfg_err_o)
  );

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      assign clr_vec[g] = clr_we_i && (int'(clr_pin_i) == g);

      pin_glitch_filter u_filt (
        .clk      (clk),
        .rst_n    (rst_sync_q),
        .raw_i    (pin_i[g]),
        .filt_en_i(filt_en[g]),
        .level_o  (lvl[g])
      );

      pin_edge_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_sync_q),
        .level_i (lvl[g]),
        .irq_en_i(irq_en[g]),
        .mode_i  (mode[g]),
        .clr_i   (clr_vec[g]),
        .flag_o  (flags[g])
      );
    end
  endgenerate

  assign flags_o = flags;
  assign level_o = lvl;
  assign irq_o   = |(flags & irq_en);

  // R11
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_o |-> (flags_o != '0));

endmodule

// File: tb/pin_event_irq_tb_top.sv
module pin_event_irq_tb_top;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_i;
  logic          cfg_we, cfg_filt, cfg_irq, clr_we;
  logic [2:0]    cfg_pin, clr_pin;
  logic [1:0]    cfg_mode;
  logic          cfg_err, irq;
  logic [NP-1:0] flags, level;

  always #10 clk = ~clk;

  pin_event_irq #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .cfg_we_i(cfg_we), .cfg_pin_i(cfg_pin), .cfg_filt_i(cfg_filt),
    .cfg_irq_i(cfg_irq), .cfg_mode_i(cfg_mode), .cfg_err_o(cfg_err),
    .clr_we_i(clr_we), .clr_pin_i(clr_pin),
    .flags_o(flags), .level_o(level), .irq_o(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int         due;
    string      req;
    int         sel;
    logic [7:0] mask;
    logic [7:0] exp;
  } item_t;
  item_t sb[$];

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0:       return flags;
      1:       return level;
      2:       return {7'b0, irq};
      default: return {7'b0, cfg_err};
    endcase
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic push(int dly, string req, int sel, logic [7:0] mask, logic [7:0] exp);
    item_t it;
    it.due = cyc + dly; it.req = req; it.sel = sel; it.mask = mask; it.exp = exp;
    sb.push_back(it);
  endtask

  // monitor: compare due scoreboard items away from the active edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        check(sb[i].req, observe(sb[i].sel) & sb[i].mask, sb[i].exp & sb[i].mask);
        sb.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int p, bit f, bit ie, logic [1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin = 3'(p); cfg_filt = f; cfg_irq = ie; cfg_mode = m;
    push(1, "R2", 3, 8'h01, {7'b0, (m == 2'd3)});
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr(int p);
    @(negedge clk);
    clr_we = 1'b1; clr_pin = 3'(p);
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic set_pin(int p, bit v);
    @(negedge clk);
    pin_i[p] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 50000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pin_i = '0;
    cfg_we = 0; cfg_filt = 0; cfg_irq = 0; cfg_mode = 0; cfg_pin = 0;
    clr_we = 0; clr_pin = 0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R12 reset state
    check("R12", flags, 8'h00);
    check("R12", level, 8'h00);
    check("R12", {7'b0, irq}, 8'h00);
    check("R12", {7'b0, cfg_err}, 8'h00);

    // R1 / R3: any-change mode, rising transition, no filter
    cfg(0, 0, 1, 2'd0);
    set_pin(0, 1);
    push(1, "R3", 1, 8'h01, 8'h00);
    push(2, "R3", 1, 8'h01, 8'h01);
    push(2, "R3", 0, 8'h01, 8'h00);
    push(3, "R1", 0, 8'h01, 8'h01);
    push(3, "R11", 2, 8'h01, 8'h01);
    tick(6);
    clr(0);
    check("R9", flags & 8'h01, 8'h00);
    set_pin(0, 0);
    push(3, "R1", 0, 8'h01, 8'h01);
    tick(6);

    // R9: clearing another pin keeps pin 0
    clr(1);
    check("R9", flags & 8'h01, 8'h01);
    clr(0);
    check("R9", flags & 8'h01, 8'h00);

    // R1 rising only on pin 1
    cfg(1, 0, 1, 2'd1);
    set_pin(1, 1);
    push(3, "R1", 0, 8'h02, 8'h02);
    tick(6);
    clr(1);
    set_pin(1, 0);
    push(4, "R1", 0, 8'h02, 8'h00);
    tick(6);

    // R1 falling only on pin 2
    cfg(2, 0, 1, 2'd2);
    set_pin(2, 1);
    push(4, "R1", 0, 8'h04, 8'h00);
    tick(6);
    set_pin(2, 0);
    push(3, "R1", 0, 8'h04, 8'h04);
    tick(6);
    clr(2);

    // R2: invalid code keeps pin 1 as rising, enabled, unfiltered
    cfg(1, 1, 0, 2'd3);
    set_pin(1, 1);
    push(2, "R2", 1, 8'h02, 8'h02);
    push(3, "R2", 0, 8'h02, 8'h02);
    tick(6);
    clr(1);
    set_pin(1, 0);
    tick(6);

    // R5: filtered pin 3, exact latency
    cfg(3, 1, 1, 2'd0);
    set_pin(3, 1);
    push(3, "R5", 1, 8'h08, 8'h00);
    push(4, "R5", 1, 8'h08, 8'h08);
    push(4, "R5", 0, 8'h08, 8'h00);
    push(5, "R5", 0, 8'h08, 8'h08);
    tick(8);
    clr(3);

    // R4: one-clock low excursion is rejected
    set_pin(3, 0);
    set_pin(3, 1);
    for (int d = 1; d <= 6; d++) push(d, "R4", 1, 8'h08, 8'h08);
    push(6, "R4", 0, 8'h08, 8'h00);
    tick(8);
    // R4: excursion between two edges
    @(negedge clk);
    #2 pin_i[3] = 1'b0;
    #3 pin_i[3] = 1'b1;
    push(6, "R4", 1, 8'h08, 8'h08);
    push(6, "R4", 0, 8'h08, 8'h00);
    tick(8);

    // R6: excursion near two clocks, either outcome, must settle
    cfg(4, 1, 1, 2'd1);
    @(negedge clk);
    #3 pin_i[4] = 1'b1;
    #30 pin_i[4] = 1'b0;
    tick(10);
    check("R6", level & 8'h10, 8'h00);
    clr(4);

    // R8 / R7: disabled pin 5 toggles, no flag anywhere
    cfg(5, 0, 0, 2'd0);
    set_pin(5, 1);
    push(4, "R8", 0, 8'h20, 8'h00);
    push(4, "R7", 0, 8'h21, 8'h00);
    tick(6);

    // R11 / R8: disabling a flagged pin
    cfg(0, 0, 1, 2'd0);
    set_pin(0, 1);
    push(3, "R1", 0, 8'h01, 8'h01);
    tick(6);
    cfg(0, 0, 0, 2'd0);
    check("R11", {7'b0, irq}, 8'h00);
    check("R8", flags & 8'h01, 8'h01);
    set_pin(0, 0);
    push(4, "R8", 0, 8'h01, 8'h01);
    tick(6);
    cfg(0, 0, 1, 2'd0);
    check("R11", {7'b0, irq}, 8'h01);
    clr(0);
    check("R11", {7'b0, irq}, 8'h00);

    // R10: set and clear on the same edge
    cfg(6, 0, 1, 2'd0);
    set_pin(6, 1);
    push(3, "R10", 0, 8'h40, 8'h40);
    tick(1);
    clr(6);
    tick(2);
    check("R10", flags & 8'h40, 8'h40);
    clr(6);
    check("R10", flags & 8'h40, 8'h00);

    tick(5);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    finish_run();
  end

endmodule